// File: doc/BRIEF.md
# Tile Transpose-and-Accumulate Engine

The engine produces one square output tile C = B + Aᵀ, where every tile holds BS×BS signed 32-bit integers and the result lands in its own storage, apart from both operands. A single read stream brings in the tile of A first and then the tile of B. The result leaves through a single write stream. Both streams use a plain valid/ready handshake and carry W consecutive elements of one row on each beat. A one-cycle `start` launches a tile, and a one-cycle `done` marks its completion.

Work on a tile runs in three phases, one after the other. In the first, the A tile fills a banked, skewed staging buffer. In the second, that buffer is read column-wise while B arrives row-wise. W adder lanes form the sums and write them into a second buffer. In the third, the second buffer drains to the write stream. Any single phase either reads or writes external memory, never both, so a replicated copy of the engine can sit behind each memory bank.

Top module: `tp_transpose_add`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `done`, `rd_ready` and `wr_valid` are all low.
- R2: A `start` sampled while idle puts `rd_ready` high in the next cycle, and `wr_valid` stays low.
- R3: The first BS·BS/W accepted read beats are the A tile in row-major order. Beat n carries row n/(BS/W) and column block n mod (BS/W). Lane j occupies bits [32j+31:32j] and holds column (n mod (BS/W))·W + j.
- R4: The next BS·BS/W accepted read beats are the B tile, in the same layout as A. The result element at row i, column c equals B[i][c] + A[c][i].
- R5: After the last B beat, `wr_valid` rises and the C tile leaves in the same row-major beat layout. While `wr_ready` is low, a beat that has been offered stays valid with unchanged data.
- R6: `rd_ready` and `wr_valid` are never high in the same cycle.
- R7: `done` is high for exactly one cycle, the cycle after the last C beat is accepted. After that, `rd_ready` and `wr_valid` stay low until the next `start`, and `rd_valid` has no effect in that interval.
- R8: A `start` that arrives while a tile is in progress is ignored, and the tile completes with correct results.
- R9: Addition is 32-bit two's-complement and wraps around on overflow.
- R10: Idle cycles on `rd_valid` and stalls on `wr_ready` change only the timing, never the values or the order of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one tile while idle |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | input | 1 | Read-stream beat valid |
| rd_ready | output | 1 | Engine accepts a read beat |
| rd_data | input | W·32 | Read-stream beat, W elements of one row |
| wr_valid | output | 1 | Write-stream beat valid |
| wr_ready | input | 1 | Memory accepts a write beat |
| wr_data | output | W·32 | Write-stream beat, W elements of one row of C |

## Verification
The stimulus gives every A element a distinct value. A design that skipped the transpose, or that placed a lane in the wrong bank of the skewed buffer, therefore puts values visibly in the wrong column. A run with large operands forces wrap-around, which catches any saturating or widened adder. Further runs insert read gaps and write stalls, and a held beat that drifts or a counter that advances without a handshake then shows up as a wrong or lost element. Starts issued in the middle of the B phase and in the middle of the drain check that the engine neither restarts the load nor truncates the tile. A reset in the middle of a load must leave the engine idle and able to run a clean tile afterwards.

// File: rtl/tp_pkg.sv
package tp_pkg;

    localparam int unsigned ELEM_W = 32;

    typedef logic [ELEM_W-1:0] elem_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_SUM   = 2'd2,
        PH_DRAIN = 2'd3
    } phase_e;

    // Lane that bank 'bank' serves when the skew is 'skew' (inverse of bank_of_lane).
    function automatic int unsigned lane_of_bank(int unsigned bank, int unsigned skew,
                                                 int unsigned w);
        return (bank + w - (skew % w)) % w;
    endfunction

    // Bank holding lane 'lane' under skew 'skew'.
    function automatic int unsigned bank_of_lane(int unsigned lane, int unsigned skew,
                                                 int unsigned w);
        return (lane + skew) % w;
    endfunction

    function automatic elem_t wrap_add(elem_t x, elem_t y);
        return x + y;
    endfunction

    function automatic phase_e next_phase(phase_e p);
        unique case (p)
            PH_LOAD: return PH_SUM;
            PH_SUM:  return PH_DRAIN;
            default: return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/tp_seq.sv
module tp_seq
    import tp_pkg::*;
#(
    parameter int unsigned BS = 8,
    parameter int unsigned W  = 4,
    localparam int unsigned KB    = BS / W,
    localparam int unsigned ROW_W = (BS > 1) ? $clog2(BS) : 1,
    localparam int unsigned BLK_W = (KB > 1) ? $clog2(KB) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             rd_valid,
    input  logic             wr_ready,
    output logic [ROW_W-1:0] row,
    output logic [BLK_W-1:0] blk,
    output logic             rd_ready,
    output logic             wr_valid,
    output logic             load_we,
    output logic             sum_we,
    output logic             done
);

    phase_e           ph_q;
    logic [ROW_W-1:0] row_q;
    logic [BLK_W-1:0] blk_q;
    logic             done_q;
    logic             step;
    logic             last_beat;

    always_comb begin
        rd_ready  = (ph_q == PH_LOAD) || (ph_q == PH_SUM);
        wr_valid  = (ph_q == PH_DRAIN);
        load_we   = (ph_q == PH_LOAD) && rd_valid;
        sum_we    = (ph_q == PH_SUM) && rd_valid;
        step      = load_we || sum_we || (wr_valid && wr_ready);
        last_beat = (row_q == ROW_W'(BS - 1)) && (blk_q == BLK_W'(KB - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            row_q  <= '0;
            blk_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (ph_q == PH_IDLE) begin
                if (start) begin
                    ph_q  <= PH_LOAD;
                    row_q <= '0;
                    blk_q <= '0;
                end
            end else if (step) begin
                if (last_beat) begin
                    row_q  <= '0;
                    blk_q  <= '0;
                    ph_q   <= next_phase(ph_q);
                    done_q <= (ph_q == PH_DRAIN);
                end else if (blk_q == BLK_W'(KB - 1)) begin
                    blk_q <= '0;
                    row_q <= row_q + 1'b1;
                end else begin
                    blk_q <= blk_q + 1'b1;
                end
            end
        end
    end

    assign row  = row_q;
    assign blk  = blk_q;
    assign done = done_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (ph_q == PH_IDLE) && !rd_ready && !wr_valid); // R7
    AST_LOAD_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_ready) |-> $past(start)); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ph_q != PH_IDLE && start) |=> (ph_q != PH_LOAD || $past(ph_q) == PH_LOAD)); // R8

endmodule

// File: rtl/tp_skew_buf.sv
module tp_skew_buf
    import tp_pkg::*;
#(
    parameter int unsigned BS = 8,
    parameter int unsigned W  = 4,
    localparam int unsigned KB    = BS / W,
    localparam int unsigned ROW_W = (BS > 1) ? $clog2(BS) : 1,
    localparam int unsigned BLK_W = (KB > 1) ? $clog2(KB) : 1,
    localparam int unsigned DEPTH = BS * KB,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LW    = (W > 1) ? $clog2(W) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [ROW_W-1:0]           wr_row,
    input  logic [BLK_W-1:0]           wr_blk,
    input  logic [W-1:0][ELEM_W-1:0]   wr_lanes,
    input  logic [ROW_W-1:0]           rd_row,
    input  logic [BLK_W-1:0]           rd_blk,
    output logic [W-1:0][ELEM_W-1:0]   rd_lanes
);

    logic [LW-1:0] w_sel  [W];
    logic [LW-1:0] r_sel  [W];
    logic [AW-1:0] w_addr [W];
    logic [AW-1:0] r_addr [W];
    elem_t         bank_rd [W];
    logic [W-1:0]  w_hit;
    logic [W-1:0]  r_hit;

    // Element (r, c) lives in bank (r + c) mod W at word r*KB + c/W, so a row
    // segment and a column segment both touch every bank exactly once.
    for (genvar b = 0; b < W; b++) begin : g_bank
        elem_t mem [DEPTH];

        assign w_sel[b]  = LW'(lane_of_bank(b, 32'(wr_row), W));
        assign w_addr[b] = AW'(32'(wr_row) * KB + 32'(wr_blk));
        assign r_sel[b]  = LW'(lane_of_bank(b, 32'(rd_row), W));
        assign r_addr[b] = AW'((32'(rd_blk) * W + 32'(r_sel[b])) * KB + 32'(rd_row) / W);

        always_ff @(posedge clk) begin
            if (we) begin
                mem[w_addr[b]] <= wr_lanes[w_sel[b]];
            end
        end

        assign bank_rd[b] = mem[r_addr[b]];
    end

    for (genvar j = 0; j < W; j++) begin : g_unrot
        assign rd_lanes[j] = bank_rd[LW'(bank_of_lane(j, 32'(rd_row), W))];
    end

    always_comb begin
        w_hit = '0;
        r_hit = '0;
        for (int b = 0; b < W; b++) begin
            w_hit[w_sel[b]] = 1'b1;
            r_hit[r_sel[b]] = 1'b1;
        end
    end

    AST_WR_BANKS_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        we |-> ($countones(w_hit) == W)); // R3
    AST_RD_BANKS_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        !we |-> ($countones(r_hit) == W)); // R4

endmodule

// File: rtl/tp_add_lanes.sv
module tp_add_lanes
    import tp_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0][ELEM_W-1:0] a_lanes,
    input  logic [W-1:0][ELEM_W-1:0] b_lanes,
    output logic [W-1:0][ELEM_W-1:0] s_lanes
);

    for (genvar j = 0; j < W; j++) begin : g_lane
        assign s_lanes[j] = wrap_add(a_lanes[j], b_lanes[j]);
    end

endmodule

// File: rtl/tp_transpose_add.sv
module tp_transpose_add
    import tp_pkg::*;
#(
    parameter int unsigned BS = 8,
    parameter int unsigned W  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    output logic                  done,
    input  logic                  rd_valid,
    output logic                  rd_ready,
    input  logic [W*ELEM_W-1:0]   rd_data,
    output logic                  wr_valid,
    input  logic                  wr_ready,
    output logic [W*ELEM_W-1:0]   wr_data
);

    localparam int unsigned KB    = BS / W;
    localparam int unsigned ROW_W = (BS > 1) ? $clog2(BS) : 1;
    localparam int unsigned BLK_W = (KB > 1) ? $clog2(KB) : 1;
    localparam int unsigned BEATS = BS * KB;
    localparam int unsigned BA_W  = (BEATS > 1) ? $clog2(BEATS) : 1;

    typedef logic [W-1:0][ELEM_W-1:0] lanes_t;

    logic [ROW_W-1:0] row;
    logic [BLK_W-1:0] blk;
    logic             load_we;
    logic             sum_we;
    logic [BA_W-1:0]  beat_addr;
    lanes_t           in_lanes;
    lanes_t           at_lanes;
    lanes_t           sum_lanes;
    lanes_t           tile_q [BEATS];

    tp_seq #(.BS(BS), .W(W)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .rd_valid (rd_valid),
        .wr_ready (wr_ready),
        .row      (row),
        .blk      (blk),
        .rd_ready (rd_ready),
        .wr_valid (wr_valid),
        .load_we  (load_we),
        .sum_we   (sum_we),
        .done     (done)
    );

    assign in_lanes = rd_data;

    tp_skew_buf #(.BS(BS), .W(W)) stage_i (
        .clk      (clk),
        .rst      (rst),
        .we       (load_we),
        .wr_row   (row),
        .wr_blk   (blk),
        .wr_lanes (in_lanes),
        .rd_row   (row),
        .rd_blk   (blk),
        .rd_lanes (at_lanes)
    );

    tp_add_lanes #(.W(W)) add_i (
        .a_lanes (at_lanes),
        .b_lanes (in_lanes),
        .s_lanes (sum_lanes)
    );

    assign beat_addr = BA_W'(32'(row) * KB + 32'(blk));

    always_ff @(posedge clk) begin
        if (sum_we) begin
            tile_q[beat_addr] <= sum_lanes;
        end
    end

    assign wr_data = tile_q[beat_addr];

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data))); // R5
    AST_NO_SUM_WRITE_IN_DRAIN: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> (!sum_we || !wr_valid)); // R6

endmodule

// File: tb/tp_transpose_add_tb_top.sv
module tp_transpose_add_tb_top;

    localparam int BS    = 8;
    localparam int W     = 4;
    localparam int KB    = BS / W;
    localparam int BEATS = BS * KB;
    localparam int DW    = W * 32;
    localparam int NV    = 5;

    // columns: a_mul, a_off, b_mul, b_off, read gap, write stall, start while busy
    localparam logic [31:0] VEC [NV][7] = '{
        '{32'd1,          32'd0,          32'd0,          32'd0,          32'd0, 32'd0, 32'd0},
        '{32'd1,          32'd0,          32'd100,        32'd1000,       32'd0, 32'd0, 32'd0},
        '{32'd3,          32'd5,          32'd7,          32'd11,         32'd2, 32'd1, 32'd0},
        '{32'h1000_0001,  32'hFFFF_FFF0,  32'h9E37_79B9,  32'h7FFF_FFFF,  32'd0, 32'd2, 32'd0},
        '{32'd2,          32'd1,          32'd5,          32'd3,          32'd1, 32'd0, 32'd1}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          done;
    logic          rd_valid;
    logic          rd_ready;
    logic [DW-1:0] rd_data;
    logic          wr_valid;
    logic          wr_ready;
    logic [DW-1:0] wr_data;

    int   n_chk = 0;
    int   n_bad = 0;
    logic mon_en = 1'b0;

    logic [31:0]   a_m [BS][BS];
    logic [31:0]   b_m [BS][BS];
    logic [DW-1:0] exp_c [BEATS];

    always #10 clk = ~clk;

    tp_transpose_add #(.BS(BS), .W(W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .done     (done),
        .rd_valid (rd_valid),
        .rd_ready (rd_ready),
        .rd_data  (rd_data),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .wr_data  (wr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] beat(input bit use_b, input int n);
        logic [DW-1:0] v;
        int r = n / KB;
        int k = n % KB;
        for (int j = 0; j < W; j++) begin
            v[j*32 +: 32] = use_b ? b_m[r][k*W+j] : a_m[r][k*W+j];
        end
        return v;
    endfunction

    task automatic build(input logic [31:0] am, input logic [31:0] ao,
                         input logic [31:0] bm, input logic [31:0] bo);
        for (int r = 0; r < BS; r++) begin
            for (int c = 0; c < BS; c++) begin
                a_m[r][c] = am * 32'(r * BS + c) + ao;
                b_m[r][c] = bm * 32'(r * BS + c) + bo;
            end
        end
        // R4: C[i][c] = B[i][c] + A[c][i], 32-bit wrap (R9)
        for (int i = 0; i < BS; i++) begin
            for (int k = 0; k < KB; k++) begin
                for (int j = 0; j < W; j++) begin
                    exp_c[i*KB+k][j*32 +: 32] = b_m[i][k*W+j] + a_m[k*W+j][i];
                end
            end
        end
    endtask

    task automatic send(input bit use_b, input int gap, input bit mid);
        for (int n = 0; n < BEATS; n++) begin
            if (gap > 0 && (n % 3) == 1) begin
                repeat (gap) begin
                    @(negedge clk);
                    start    = 1'b0;
                    rd_valid = 1'b0;
                    rd_data  = '1;
                end
            end
            @(negedge clk);
            start    = mid && (n == BEATS / 2);
            rd_valid = 1'b1;
            rd_data  = beat(use_b, n);
            while (!rd_ready) begin
                @(negedge clk);
                start = 1'b0;
            end
        end
        @(negedge clk);
        start    = 1'b0;
        rd_valid = 1'b0;
    endtask

    task automatic collect(input int stall, input bit mid, input string tag);
        for (int n = 0; n < BEATS; n++) begin
            if (stall > 0 && (n % 2) == 1) begin
                repeat (stall) begin
                    @(negedge clk);
                    start    = 1'b0;
                    wr_ready = 1'b0;
                    chk(wr_valid && wr_data == exp_c[n], "R5 hold under stall",
                        wr_data, exp_c[n]);
                end
            end
            @(negedge clk);
            wr_ready = 1'b1;
            start    = mid && (n == 4);
            while (!wr_valid) begin
                @(negedge clk);
                start = 1'b0;
            end
            chk(wr_data == exp_c[n], tag, wr_data, exp_c[n]);
            chk(!done, "R7 no early done", DW'(done), '0);
        end
        @(negedge clk);
        start = 1'b0;
        chk(done && !wr_valid, "R7 done pulse", DW'({done, wr_valid}), DW'(2'b10));
        wr_ready = 1'b0;
        @(negedge clk);
        chk(!done, "R7 done single cycle", DW'(done), '0);
    endtask

    task automatic run_tile(input logic [31:0] am, input logic [31:0] ao,
                            input logic [31:0] bm, input logic [31:0] bo,
                            input int gap, input int stall, input bit mid,
                            input string tag);
        build(am, ao, bm, bo);
        @(negedge clk);
        chk(!rd_ready, "R2 idle before start", DW'(rd_ready), '0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(rd_ready && !wr_valid, "R2 load entry", DW'({rd_ready, wr_valid}), DW'(2'b10));
        send(1'b0, gap, 1'b0);
        send(1'b1, gap, mid);
        collect(stall, mid, tag);
        // R7: after done, the read stream is ignored
        repeat (3) begin
            @(negedge clk);
            rd_valid = 1'b1;
            rd_data  = {W{32'hDEAD_BEEF}};
            chk(!rd_ready && !wr_valid, "R7 idle after done",
                DW'({rd_ready, wr_valid}), '0);
        end
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            chk(!(rd_ready && wr_valid), "R6 one direction", DW'({rd_ready, wr_valid}), '0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        start    = 1'b0;
        rd_valid = 1'b0;
        rd_data  = '0;
        wr_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(!done && !rd_ready && !wr_valid, "R1 reset state",
            DW'({done, rd_ready, wr_valid}), '0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !rd_ready && !wr_valid, "R1 after reset",
            DW'({done, rd_ready, wr_valid}), '0);
        mon_en = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            case (i)
                0:       tag = "R3 R4 R5 pure transpose";
                1:       tag = "R3 R4 R5 transpose plus B";
                2:       tag = "R10 gaps and stalls";
                3:       tag = "R9 wrap-around";
                default: tag = "R8 start while busy";
            endcase
            run_tile(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3],
                     int'(VEC[i][4]), int'(VEC[i][5]), VEC[i][6][0], tag);
        end

        // R1: reset in the middle of a load, then a clean tile
        build(32'd5, 32'd9, 32'd2, 32'd4);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 5; n++) begin
            @(negedge clk);
            rd_valid = 1'b1;
            rd_data  = beat(1'b0, n);
        end
        @(negedge clk);
        rd_valid = 1'b0;
        rst      = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!done && !rd_ready && !wr_valid, "R1 mid-run reset",
            DW'({done, rd_ready, wr_valid}), '0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !rd_ready && !wr_valid, "R1 idle after mid-run reset",
            DW'({done, rd_ready, wr_valid}), '0);
        run_tile(32'd5, 32'd9, 32'd2, 32'd4, 0, 0, 1'b0, "R1 R4 tile after reset");

        mon_en = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule